// File: doc/BRIEF.md
# Serial Fault Flag Frame Generator

This block reports supervisor faults on a single wire as a repeating timed frame. The supervisor pulses a fault strobe for each confirmed fault on either of two channels. The block keeps those flags and then sends a frame of fixed length, measured in time units marked by a tick input. The frame opens with a high alert field. The five flag slots of channel 1 follow, then a low gap, then the five flag slots of channel 2, then a high closing field, and last some low padding.

Frames repeat back to back for as long as a fault episode lasts. The episode ends at a frame boundary once both power-good inputs are high, so the frame in progress is always sent in full. The kept flags are then cleared, and the line stays low until the next strobe.

Top module: `fault_frame_gen`

## Requirements
- R1: While synchronous reset is asserted, and on the first cycle after it, `fault_line` is low.
- R2: When no frame is being sent, `fault_line` is low.
- R3: If any strobe bit is high while the block is idle, a frame starts on the next cycle at unit 0. Units 0 to 3 are driven high (the alert field).
- R4: Flag bit k of each strobe vector has this meaning: bit 0 overcurrent, bit 1 overtemperature, bit 2 undervoltage, bit 3 first-level overvoltage, bit 4 second-level overvoltage. Channel 1 slot k covers units 4+2k and 5+2k. Channel 2 slot k covers units 16+2k and 17+2k. A slot is high exactly when its displayed flag is set.
- R5: Units 14 and 15, the gap between the two channels, are low.
- R6: Units 26 to 29 (the closing field) are high. Units 30 to 35 (the padding) are low.
- R7: A frame lasts 36 units. After unit 35, the next frame starts at unit 0 without a pause unless transmission stops.
- R8: A flag stays set from its strobe until transmission ends. The flags shown in a frame are the ones captured when that frame starts. A strobe that arrives during a frame first shows in the next frame.
- R9: Transmission stops on the tick that ends unit 35 if both `pgood` bits are high and no strobe is present. The line is low from the next cycle on.
- R10: When transmission stops, all kept flags are cleared. A later episode shows only the faults strobed after that stop.
- R11: The frame position advances only on cycles where `unit_tick` is high. Without a tick, the line holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| unit_tick | input | 1 | One-cycle pulse that marks the end of each time unit |
| ch1_fault_stb | input | 5 | Channel 1 fault strobes, bit order as in R4 |
| ch2_fault_stb | input | 5 | Channel 2 fault strobes, bit order as in R4 |
| pgood | input | 2 | Power-good status, bit 0 for channel 1 and bit 1 for channel 2 |
| fault_line | output | 1 | Serial fault frame output |

## Verification
Several properties are checked on every cycle: the line is low while idle, the frame position stays in range and holds without a tick, the alert field is high, a strobe in idle starts unit 0, kept flags never drop while a frame runs, and the stop rule clears the flags. The exact slot positions and bit order, the gap, closing and padding levels, and the one-frame delay before a mid-frame strobe is shown can only be seen by comparing the line against the bench's layout model. That model runs under directed scenarios and random strobe, tick and power-good patterns. Those scenarios also show that a new episode after a stop carries only fresh flags.

// File: rtl/fault_frame_pkg.sv
// Package: shared flag definitions for the fault frame generator.
// Assumes every channel reports the same five fault kinds in a fixed order.
package fault_frame_pkg;
    localparam int FLAG_COUNT = 5;
    localparam int CHAN_COUNT = 2;

    // Bit position of each fault kind inside a channel flag vector
    typedef enum int {
        FLG_OVERCURRENT = 0,
        FLG_OVERTEMP    = 1,
        FLG_UNDERVOLT   = 2,
        FLG_OVERVOLT_LO = 3,
        FLG_OVERVOLT_HI = 4
    } flag_idx_e;

    typedef logic [FLAG_COUNT-1:0] flag_vec_t;
endpackage

// File: rtl/fault_frame_seq.sv
// Frame sequencer: tracks whether a fault episode is being sent and which
// time unit of the frame is current. It decides start, wrap and stop.
// Assumes the tick is a one-cycle pulse. Stopping needs both power-good bits
// high and no strobe at the frame's last tick.
module fault_frame_seq #(
    parameter int FRAME_UNITS = 36,
    parameter int UW          = $clog2(FRAME_UNITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          any_stb_i,
    input  logic          pg_ok_i,
    output logic          active_o,
    output logic [UW-1:0] unit_o,
    output logic          start_o,
    output logic          wrap_o,
    output logic          stop_o
);
    localparam logic [UW-1:0] LAST_UNIT = UW'(FRAME_UNITS - 1);

    logic frame_end;

    // Decode the frame-boundary events from the current position
    always_comb begin
        frame_end = active_o && tick_i && (unit_o == LAST_UNIT);
        start_o   = !active_o && any_stb_i;
        stop_o    = frame_end && pg_ok_i && !any_stb_i;
        wrap_o    = frame_end && !stop_o;
    end

    // Advance the unit position and the episode state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            unit_o   <= '0;
        end else if (start_o) begin
            active_o <= 1'b1;
            unit_o   <= '0;
        end else if (stop_o) begin
            active_o <= 1'b0;
            unit_o   <= '0;
        end else if (wrap_o) begin
            unit_o   <= '0;
        end else if (active_o && tick_i) begin
            unit_o   <= unit_o + 1'b1;
        end
    end
endmodule

// File: rtl/fault_flag_latch.sv
// Flag latch: keeps the per-channel fault flags for the whole episode and
// captures a display copy at every frame start, so that slots stay steady
// within a frame. Assumes start, wrap and stop are mutually exclusive.
module fault_flag_latch
    import fault_frame_pkg::*;
#(
    parameter int NCH = CHAN_COUNT,
    parameter int NF  = FLAG_COUNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH*NF-1:0] stb_i,
    input  logic            start_i,
    input  logic            wrap_i,
    input  logic            stop_i,
    output logic [NCH*NF-1:0] kept_o,
    output logic [NCH*NF-1:0] shown_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [NF-1:0] stb_c;
        logic [NF-1:0] kept_q;
        logic [NF-1:0] shown_q;

        assign stb_c = stb_i[c*NF +: NF];

        // Gather strobes into sticky flags and snapshot them per frame
        always_ff @(posedge clk) begin
            if (!rst_n || stop_i) begin
                kept_q  <= '0;
                shown_q <= '0;
            end else begin
                kept_q <= kept_q | stb_c;
                if (start_i || wrap_i)
                    shown_q <= kept_q | stb_c;
            end
        end

        assign kept_o[c*NF +: NF]  = kept_q;
        assign shown_o[c*NF +: NF] = shown_q;
    end
endmodule

// File: rtl/fault_frame_enc.sv
// Slot encoder: maps the current unit position and the displayed flags onto
// the line level. Assumes the layout fits inside the frame length, and fills
// the rest of the frame with low padding.
module fault_frame_enc #(
    parameter int NF          = 5,
    parameter int ALERT_UNITS = 4,
    parameter int SLOT_UNITS  = 2,
    parameter int GAP_UNITS   = 2,
    parameter int END_UNITS   = 4,
    parameter int UW          = 6
) (
    input  logic            active_i,
    input  logic [UW-1:0]   unit_i,
    input  logic [2*NF-1:0] shown_i,
    output logic            line_o
);
    localparam int CH1_BASE = ALERT_UNITS;
    localparam int CH2_BASE = CH1_BASE + NF*SLOT_UNITS + GAP_UNITS;
    localparam int END_BASE = CH2_BASE + NF*SLOT_UNITS;
    localparam logic [UW-1:0] ALERT_TOP = UW'(ALERT_UNITS);
    localparam logic [UW-1:0] END_LO    = UW'(END_BASE);
    localparam logic [UW-1:0] END_HI    = UW'(END_BASE + END_UNITS);

    logic [2*NF-1:0] slot_hit;

    for (genvar s = 0; s < 2*NF; s++) begin : g_slot
        localparam int BASE = (s < NF) ? CH1_BASE : CH2_BASE;
        localparam int K    = (s < NF) ? s : s - NF;
        localparam logic [UW-1:0] LO = UW'(BASE + K*SLOT_UNITS);
        localparam logic [UW-1:0] HI = UW'(BASE + (K+1)*SLOT_UNITS);
        // Flag slot is high when the position lies in it and its flag is shown
        assign slot_hit[s] = shown_i[s] && (unit_i >= LO) && (unit_i < HI);
    end

    // Combine fixed fields and flag slots into the line level
    always_comb begin
        line_o = 1'b0;
        if (active_i) begin
            line_o = (unit_i < ALERT_TOP)
                  || ((unit_i >= END_LO) && (unit_i < END_HI))
                  || (|slot_hit);
        end
    end
endmodule

// File: rtl/fault_frame_gen.sv
// Top: serial fault flag frame generator. Strobes from two channels start a
// fault episode. Timed frames repeat until power-good returns at a frame end.
// Assumes strobes and power-good are already synchronous to clk.
module fault_frame_gen #(
    parameter int FRAME_UNITS = 36,
    parameter int ALERT_UNITS = 4,
    parameter int SLOT_UNITS  = 2,
    parameter int GAP_UNITS   = 2,
    parameter int END_UNITS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unit_tick,
    input  logic [4:0] ch1_fault_stb,
    input  logic [4:0] ch2_fault_stb,
    input  logic [1:0] pgood,
    output logic       fault_line
);
    import fault_frame_pkg::*;

    localparam int NF = FLAG_COUNT;
    localparam int UW = $clog2(FRAME_UNITS);

    logic [2*NF-1:0] stb_all;
    logic [2*NF-1:0] kept_flags;
    logic [2*NF-1:0] shown_flags;
    logic            any_stb;
    logic            active;
    logic [UW-1:0]   unit;
    logic            frame_start, frame_wrap, frame_stop;

    // Collect both channels' strobes into one vector
    always_comb begin
        stb_all = {ch2_fault_stb, ch1_fault_stb};
        any_stb = |stb_all;
    end

    fault_frame_seq #(
        .FRAME_UNITS(FRAME_UNITS),
        .UW(UW)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .tick_i(unit_tick),
        .any_stb_i(any_stb),
        .pg_ok_i(&pgood),
        .active_o(active),
        .unit_o(unit),
        .start_o(frame_start),
        .wrap_o(frame_wrap),
        .stop_o(frame_stop)
    );

    fault_flag_latch #(
        .NCH(2),
        .NF(NF)
    ) u_latch (
        .clk(clk),
        .rst_n(rst_n),
        .stb_i(stb_all),
        .start_i(frame_start),
        .wrap_i(frame_wrap),
        .stop_i(frame_stop),
        .kept_o(kept_flags),
        .shown_o(shown_flags)
    );

    fault_frame_enc #(
        .NF(NF),
        .ALERT_UNITS(ALERT_UNITS),
        .SLOT_UNITS(SLOT_UNITS),
        .GAP_UNITS(GAP_UNITS),
        .END_UNITS(END_UNITS),
        .UW(UW)
    ) u_enc (
        .active_i(active),
        .unit_i(unit),
        .shown_i(shown_flags),
        .line_o(fault_line)
    );
endmodule

// File: rtl/fault_frame_chk.sv
// Checker: cycle-level properties of the fault frame generator, bound to the
// top module. Assumes the synchronous active-low reset is low from time zero.
module fault_frame_chk #(
    parameter int FRAME_UNITS = 36,
    parameter int ALERT_UNITS = 4,
    parameter int NF          = 5,
    parameter int UW          = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            any_stb,
    input logic [1:0]      pgood,
    input logic            active,
    input logic [UW-1:0]   unit,
    input logic [2*NF-1:0] kept,
    input logic            line
);
    localparam logic [UW-1:0] LAST_U  = UW'(FRAME_UNITS - 1);
    localparam logic [UW-1:0] ALERT_U = UW'(ALERT_UNITS);

    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !line); // R2

    AST_UNIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        unit <= LAST_U); // R7

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !any_stb) |=> $stable(unit)); // R11

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && any_stb) |=> (active && unit == '0)); // R3

    AST_ALERT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (active && unit < ALERT_U) |-> line); // R3

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> (!active || ((kept & $past(kept)) == $past(kept)))); // R8

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && unit == LAST_U && (&pgood) && !any_stb)
        |=> (!active && kept == '0)); // R9
endmodule

bind fault_frame_gen fault_frame_chk #(
    .FRAME_UNITS(FRAME_UNITS),
    .ALERT_UNITS(ALERT_UNITS),
    .NF(NF),
    .UW(UW)
) i_chk (
    .clk(clk),
    .rst_n(rst_n),
    .tick(unit_tick),
    .any_stb(any_stb),
    .pgood(pgood),
    .active(active),
    .unit(unit),
    .kept(kept_flags),
    .line(fault_line)
);

// File: tb/test_fault_frame_gen.sv
`timescale 1ns/1ps
module test_fault_frame_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unit_tick = 1'b0;
    logic [4:0] ch1_fault_stb = '0;
    logic [4:0] ch2_fault_stb = '0;
    logic [1:0] pgood = 2'b00;
    logic       fault_line;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    fault_frame_gen i_fault_frame_gen (
        .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick),
        .ch1_fault_stb(ch1_fault_stb), .ch2_fault_stb(ch2_fault_stb),
        .pgood(pgood), .fault_line(fault_line)
    );

    // Reference state built from the requirements
    logic       m_act;
    int         m_unit;
    logic [4:0] m_k1, m_k2, m_s1, m_s2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act <= 1'b0; m_unit <= 0;
            m_k1 <= '0; m_k2 <= '0; m_s1 <= '0; m_s2 <= '0;
        end else if (!m_act) begin
            if ((|ch1_fault_stb) || (|ch2_fault_stb)) begin
                m_act <= 1'b1; m_unit <= 0;
                m_k1 <= ch1_fault_stb; m_k2 <= ch2_fault_stb;
                m_s1 <= ch1_fault_stb; m_s2 <= ch2_fault_stb;
            end
        end else if (unit_tick && m_unit == 35) begin
            if (pgood == 2'b11 && ch1_fault_stb == 0 && ch2_fault_stb == 0) begin
                m_act <= 1'b0; m_unit <= 0;
                m_k1 <= '0; m_k2 <= '0; m_s1 <= '0; m_s2 <= '0;
            end else begin
                m_unit <= 0;
                m_k1 <= m_k1 | ch1_fault_stb; m_k2 <= m_k2 | ch2_fault_stb;
                m_s1 <= m_k1 | ch1_fault_stb; m_s2 <= m_k2 | ch2_fault_stb;
            end
        end else begin
            if (unit_tick) m_unit <= m_unit + 1;
            m_k1 <= m_k1 | ch1_fault_stb; m_k2 <= m_k2 | ch2_fault_stb;
        end
    end

    function automatic logic exp_line(logic act, int u, logic [4:0] s1, logic [4:0] s2);
        if (!act)   return 1'b0;
        if (u < 4)  return 1'b1;
        if (u < 14) return s1[(u-4)/2];
        if (u < 16) return 1'b0;
        if (u < 26) return s2[(u-16)/2];
        if (u < 30) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string tag_of(logic act, int u);
        if (!act)   return "R2";
        if (u < 4)  return "R3";
        if (u < 14) return "R4";
        if (u < 16) return "R5";
        if (u < 26) return "R4";
        return "R6";
    endfunction

    task automatic chk(logic actual, logic expected, string tag, string what);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b (unit %0d)", tag, what, actual, expected, m_unit);
        end
    endtask

    // Wait to the falling edge and compare the line with the model
    task automatic sync();
        @(negedge clk);
        if (rst_n) chk(fault_line, exp_line(m_act, m_unit, m_s1, m_s2), tag_of(m_act, m_unit), "frame level");
    endtask

    task automatic drive(logic tk, logic [4:0] a, logic [4:0] b, logic [1:0] pg);
        unit_tick = tk; ch1_fault_stb = a; ch2_fault_stb = b; pgood = pg;
    endtask

    task automatic step(logic tk, logic [4:0] a, logic [4:0] b, logic [1:0] pg);
        sync();
        drive(tk, a, b, pg);
    endtask

    // Tick until the model reaches unit u; returns at a falling edge, undriven
    task automatic goto(int u, logic [1:0] pg);
        forever begin
            sync();
            if (m_act && m_unit == u) return;
            drive(1'b1, '0, '0, pg);
        end
    endtask

    initial begin
        #(4.0 * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_0042));
        // R1: reset holds the line low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(fault_line, 1'b0, "R1", "line during reset");
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(fault_line, 1'b0, "R1", "line after reset");

        // R2: idle with ticks and no strobes
        for (int i = 0; i < 20; i++) step(1'b1, '0, '0, 2'b01);

        // R3/R4: episode with channel 1 overcurrent and channel 2 second-level overvoltage
        drive(1'b1, 5'b00001, 5'b10000, 2'b00);
        goto(2, 2'b00);
        drive(1'b1, 5'b10000, '0, 2'b00);     // mid-frame strobe, ch1 bit 4
        goto(12, 2'b00);
        chk(fault_line, 1'b0, "R8", "mid-frame strobe shown too early");
        drive(1'b1, '0, '0, 2'b00);
        goto(0, 2'b00);
        chk(fault_line, 1'b1, "R7", "next frame alert");
        drive(1'b1, '0, '0, 2'b00);
        goto(12, 2'b00);
        chk(fault_line, 1'b1, "R8", "strobe shown in next frame");
        drive(1'b1, '0, '0, 2'b11);

        // R9: power-good returns mid-frame; the frame completes, then stops
        goto(35, 2'b11);
        chk(fault_line, 1'b0, "R9", "padding before stop");
        drive(1'b1, '0, '0, 2'b11);
        for (int i = 0; i < 6; i++) begin
            sync();
            chk(fault_line, 1'b0, "R9", "line after stop");
            drive(1'b1, '0, '0, 2'b11);
        end

        // R10: new episode shows only fresh flags
        drive(1'b0, '0, 5'b00100, 2'b11);
        goto(4, 2'b11);
        chk(fault_line, 1'b0, "R10", "old ch1 flag cleared");
        drive(1'b1, '0, '0, 2'b11);
        goto(20, 2'b11);
        chk(fault_line, 1'b1, "R10", "fresh ch2 undervoltage");
        drive(1'b1, '0, '0, 2'b11);
        goto(21, 2'b11);
        // R11: no tick, no advance
        drive(1'b0, '0, '0, 2'b11);
        for (int i = 0; i < 10; i++) begin
            sync();
            chk(fault_line, 1'b1, "R11", "held without tick");
            drive(1'b0, '0, '0, 2'b11);
        end
        drive(1'b1, '0, '0, 2'b11);
        sync();
        chk(fault_line, 1'b0, "R11", "advanced to next slot");
        drive(1'b1, '0, '0, 2'b11);
        while (m_act) step(1'b1, '0, '0, 2'b11);

        // Random phase
        begin
            logic [1:0] pg_r = 2'b00;
            for (int i = 0; i < 30000; i++) begin
                logic [4:0] a, b;
                a = (($urandom % 60) == 0) ? 5'($urandom) : 5'b0;
                b = (($urandom % 60) == 0) ? 5'($urandom) : 5'b0;
                if (($urandom % 150) == 0) pg_r = 2'($urandom);
                step(1'($urandom), a, b, pg_r);
            end
        end
        // Drain to idle
        while (m_act) step(1'b1, '0, '0, 2'b11);
        step(1'b1, '0, '0, 2'b11);
        sync();
        chk(fault_line, 1'b0, "R2", "final idle");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule